// File: doc/BRIEF.md
# Oversampling baud tick generator

This block turns a system clock into the sample enable that an oversampled UART receiver and transmitter use. One sample tick is produced per oversampling period, and a bit tick marks every 16th, 8th or 3rd sample tick, depending on the selected oversampling ratio.

Two divider engines are available. The accumulator engine adds a 16-bit step to a phase register on every clock and emits a tick on every carry out, so the tick rate is the clock rate times step/65536. The eighths engine uses the low 13 bits of the same word as an integer clock count and the top 3 bits as a fraction in eighths. Over each group of eight sample periods, it lengthens as many periods by one clock as the fraction says. A 3x ratio always uses the accumulator engine. Holding the enable low clears every counter, so the block restarts cleanly when it is enabled again.

Top module: `baud_tick_gen`

## Requirements
- R1: `osr_sel_i` picks the oversampling ratio: 0 = 16x, 1 = 8x, 2 = 3x, 3 = 16x. With enable held high, the k-th bit tick comes with the (k·N)-th sample tick after enable, where N is the selected ratio.
- R2: In accumulator mode, a 16-bit phase starts at 0 and adds `baud_cfg_i` on every enabled clock. A sample tick follows each carry out. After C enabled clocks, floor(C·cfg/65536) ticks have been seen, and the first comes on clock ceil(65536/cfg).
- R3: In eighths mode, bits [12:0] of `baud_cfg_i` are the integer divider D and bits [15:13] are the fraction F. Within each group of eight consecutive sample periods, the first F periods last D+1 clocks and the rest last D clocks.
- R4: With the 3x ratio selected, `frac_mode_i` is ignored and the accumulator engine is used.
- R5: An integer divider of 0 in eighths mode, or a step of 0 in accumulator mode, produces no ticks.
- R6: While `en_i` is low, no ticks are output and all counters and the phase are held at zero. After `en_i` rises, the first tick comes one full period later.
- R7: A bit tick is never asserted without a sample tick in the same cycle.
- R8: In eighths mode with D of 2 or more, a sample tick is one cycle wide.
- R9: While reset is asserted, both tick outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears all state |
| osr_sel_i | input | 2 | Oversampling ratio select (0:16x, 1:8x, 2:3x, 3:16x) |
| frac_mode_i | input | 1 | 1 selects the eighths engine (ignored at 3x) |
| baud_cfg_i | input | 16 | Step value, or {fraction[2:0], integer[12:0]} |
| sample_tick_o | output | 1 | One-cycle sample enable |
| bit_tick_o | output | 1 | One-cycle tick on every N-th sample tick |

## Verification
Both ticks are registered. A tick caused by clock edge k is visible from edge k until edge k+1, so the bench raises the enable at a falling edge and samples at every following falling edge. The n-th sample after enable therefore reflects edge n. The bit tick has no extra delay: it is checked in the same sample as the sample tick it coincides with. Expected first-tick clocks and tick counts over a fixed window are computed from the period formulas, not by stepping any register copy.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  typedef enum logic [1:0] {
    OSR_16 = 2'd0,
    OSR_8  = 2'd1,
    OSR_3  = 2'd2,
    OSR_16B = 2'd3
  } osr_e;

  localparam int unsigned MAX_OSR = 16;
  localparam int unsigned OSR_CNT_W = $clog2(MAX_OSR);

  function automatic logic [OSR_CNT_W-1:0] osr_last(input logic [1:0] sel);
    case (sel)
      OSR_8:   osr_last = OSR_CNT_W'(7);
      OSR_3:   osr_last = OSR_CNT_W'(2);
      default: osr_last = OSR_CNT_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/bt_phase_acc.sv
module bt_phase_acc #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [ACC_W-1:0] step_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (!run_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= sum[ACC_W-1:0];
      tick_o <= sum[ACC_W];
    end
  end
endmodule

// File: rtl/bt_frac_div.sv
module bt_frac_div #(
  parameter int unsigned INT_W  = 13,
  parameter int unsigned FRAC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              tick_o
);
  localparam int unsigned LEN_W = INT_W + 1;

  logic [INT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] slot_q;
  logic [LEN_W-1:0]  len;
  logic              stretch, last, idle;

  // first frac_i slots of each group get one extra clock
  assign stretch = slot_q < frac_i;
  assign len     = {1'b0, int_i} + LEN_W'(stretch);
  assign last    = {1'b0, cnt_q} >= (len - LEN_W'(1));
  assign idle    = !run_i || (int_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      slot_q <= '0;
      tick_o <= 1'b0;
    end else if (idle) begin
      cnt_q  <= '0;
      slot_q <= '0;
      tick_o <= 1'b0;
    end else if (last) begin
      cnt_q  <= '0;
      slot_q <= slot_q + FRAC_W'(1);
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + INT_W'(1);
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bt_bit_div.sv
module bt_bit_div
  import baud_tick_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] osr_sel_i,
  input  logic       tick_i,
  output logic       bit_tick_o
);
  logic [OSR_CNT_W-1:0] cnt_q;
  logic                 wrap;

  assign wrap       = cnt_q >= osr_last(osr_sel_i);
  assign bit_tick_o = tick_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= wrap ? '0 : cnt_q + OSR_CNT_W'(1);
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned CFG_W = 16,
  parameter int unsigned INT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       osr_sel_i,
  input  logic             frac_mode_i,
  input  logic [CFG_W-1:0] baud_cfg_i,
  output logic             sample_tick_o,
  output logic             bit_tick_o
);
  localparam int unsigned FRAC_W = CFG_W - INT_W;

  logic use_frac, acc_tick, frac_tick;

  // 3x has no eighths engine
  assign use_frac = frac_mode_i && (osr_sel_i != OSR_3);

  bt_phase_acc #(.ACC_W(CFG_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i && !use_frac),
    .step_i (baud_cfg_i),
    .tick_o (acc_tick)
  );

  bt_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_frac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i && use_frac),
    .int_i  (baud_cfg_i[INT_W-1:0]),
    .frac_i (baud_cfg_i[CFG_W-1:INT_W]),
    .tick_o (frac_tick)
  );

  // an engine that is not running holds its tick low
  assign sample_tick_o = acc_tick | frac_tick;

  bt_bit_div u_bit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (en_i),
    .osr_sel_i  (osr_sel_i),
    .tick_i     (sample_tick_o),
    .bit_tick_o (bit_tick_o)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int unsigned CFG_W = 16,
  parameter int unsigned INT_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [1:0]       osr_sel_i,
  input logic             frac_mode_i,
  input logic [CFG_W-1:0] baud_cfg_i,
  input logic             sample_tick_o,
  input logic             bit_tick_o
);
  logic frac_on;
  assign frac_on = frac_mode_i && (osr_sel_i != 2'd2);

  a_r6_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sample_tick_o && !bit_tick_o));

  a_r6_no_tick_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> !sample_tick_o);

  a_r7_bit_in_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> sample_tick_o);

  a_r5_zero_int_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && frac_on && baud_cfg_i[INT_W-1:0] == '0) |=> !sample_tick_o);

  a_r5_zero_step_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !frac_on && baud_cfg_i == '0) |=> !sample_tick_o);

  a_r8_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && frac_on && baud_cfg_i[INT_W-1:0] >= INT_W'(2) && sample_tick_o)
      |=> !sample_tick_o);

  always_comb begin
    if (!rst_ni) a_r9_reset_low: assert (!sample_tick_o && !bit_tick_o);
  end
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.CFG_W(CFG_W), .INT_W(INT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .osr_sel_i     (osr_sel_i),
  .frac_mode_i   (frac_mode_i),
  .baud_cfg_i    (baud_cfg_i),
  .sample_tick_o (sample_tick_o),
  .bit_tick_o    (bit_tick_o)
);

// File: tb/tb_baud_tick_gen.sv
`timescale 1ns/1ps
module tb_baud_tick_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [1:0]  osr_sel_i = 2'd0;
  logic        frac_mode_i = 1'b0;
  logic [15:0] baud_cfg_i = 16'h0;
  logic        sample_tick_o, bit_tick_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  baud_tick_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .osr_sel_i(osr_sel_i),
    .frac_mode_i(frac_mode_i), .baud_cfg_i(baud_cfg_i),
    .sample_tick_o(sample_tick_o), .bit_tick_o(bit_tick_o)
  );

  // {osr_sel, frac_mode, cfg, window}
  localparam int NV = 11;
  localparam logic [34:0] VEC [NV] = '{
    {2'd0, 1'b0, 16'h8000, 16'd64},
    {2'd1, 1'b0, 16'h1000, 16'd256},
    {2'd2, 1'b0, 16'h5555, 16'd300},
    {2'd2, 1'b1, 16'h5555, 16'd300},
    {2'd0, 1'b1, 16'h6004, 16'd400},
    {2'd1, 1'b1, 16'hE002, 16'd200},
    {2'd1, 1'b1, 16'h0003, 16'd99},
    {2'd3, 1'b1, 16'hA000, 16'd80},
    {2'd0, 1'b0, 16'h0000, 16'd80},
    {2'd3, 1'b0, 16'hFFFF, 16'd100},
    {2'd0, 1'b1, 16'h0001, 16'd70}
  };

  function automatic int osr_n(input logic [1:0] s);
    return (s == 2'd1) ? 8 : (s == 2'd2) ? 3 : 16;
  endfunction

  function automatic bit is_acc(input logic [1:0] s, input logic f);
    return (f == 1'b0) || (s == 2'd2);
  endfunction

  function automatic int exp_count(input logic [1:0] s, input logic f,
                                   input logic [15:0] cfg, input int c);
    longint prod;
    int d, fr, edge_n, t, slot, len;
    if (is_acc(s, f)) begin
      prod = longint'(c) * longint'(cfg);
      return int'(prod >> 16);
    end
    d = int'(cfg[12:0]); fr = int'(cfg[15:13]);
    if (d == 0) return 0;
    edge_n = 0; t = 0; slot = 0;
    forever begin
      len = d + ((slot < fr) ? 1 : 0);
      if (edge_n + len > c) break;
      edge_n += len; t++; slot = (slot + 1) % 8;
    end
    return t;
  endfunction

  function automatic int exp_first(input logic [1:0] s, input logic f,
                                   input logic [15:0] cfg);
    if (is_acc(s, f)) return (cfg == 0) ? 0 : (65536 + int'(cfg) - 1) / int'(cfg);
    if (cfg[12:0] == 0) return 0;
    return int'(cfg[12:0]) + ((cfg[15:13] != 0) ? 1 : 0);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input int idx);
    logic [1:0] s; logic f; logic [15:0] cfg; int c;
    int quiet, nsamp, nbit, first, misalign;
    {s, f, cfg} = VEC[idx][34:16];
    c = int'(VEC[idx][15:0]);
    @(negedge clk_i);
    en_i = 1'b0; osr_sel_i = s; frac_mode_i = f; baud_cfg_i = cfg;
    quiet = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      quiet += int'(sample_tick_o) + int'(bit_tick_o);
    end
    check(quiet == 0, "R6", $sformatf("vec%0d ticks while disabled", idx), quiet, 0);
    en_i = 1'b1;
    nsamp = 0; nbit = 0; first = 0; misalign = 0;
    for (int k = 1; k <= c; k++) begin
      @(negedge clk_i);
      if (sample_tick_o) begin
        nsamp++;
        if (first == 0) first = k;
      end
      if (bit_tick_o) begin
        nbit++;
        if (!sample_tick_o) misalign++;
      end
    end
    check(first == exp_first(s, f, cfg), is_acc(s, f) ? "R2/R6" : "R3/R6",
          $sformatf("vec%0d first tick clock", idx), first, exp_first(s, f, cfg));
    check(nsamp == exp_count(s, f, cfg, c),
          (s == 2'd2 && f) ? "R4" : (cfg == 0 || (!is_acc(s, f) && cfg[12:0] == 0)) ? "R5" :
          is_acc(s, f) ? "R2" : "R3",
          $sformatf("vec%0d sample ticks", idx), nsamp, exp_count(s, f, cfg, c));
    check(nbit == exp_count(s, f, cfg, c) / osr_n(s), "R1",
          $sformatf("vec%0d bit ticks", idx), nbit, exp_count(s, f, cfg, c) / osr_n(s));
    check(misalign == 0, "R7", $sformatf("vec%0d bit tick alone", idx), misalign, 0);
    en_i = 1'b0;
  endtask

  initial begin
    int wide, n;
    // R9: reset holds outputs low even with a fast config enabled
    en_i = 1'b1; baud_cfg_i = 16'hFFFF;
    n = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      n += int'(sample_tick_o) + int'(bit_tick_o);
    end
    check(n == 0, "R9", "ticks during reset", n, 0);
    en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(i);

    // R8: eighths mode D=2 F=7, no tick lasts two cycles
    @(negedge clk_i);
    osr_sel_i = 2'd0; frac_mode_i = 1'b1; baud_cfg_i = 16'hE002; en_i = 1'b1;
    wide = 0;
    begin
      logic prev;
      prev = 1'b0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk_i);
        if (prev && sample_tick_o) wide++;
        prev = sample_tick_o;
      end
    end
    check(wide == 0, "R8", "back-to-back sample ticks", wide, 0);

    // R6: drop enable mid-run, outputs go quiet from the next edge
    @(negedge clk_i);
    en_i = 1'b0;
    n = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      n += int'(sample_tick_o);
    end
    check(n == 0, "R6", "ticks after enable dropped", n, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    errors++; checks++;
    $display("FAIL watchdog R6: cycles=%0d expected below %0d", cyc, 100000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule